// File: doc/BRIEF.md
# Windowed On-Chip RAM Controller

This block puts a small internal RAM on a CPU bus with 24-bit addresses and 16-bit data. Two fixed address windows are claimed for the RAM. The main window runs from 0xFFD800 to 0xFFEFBF. A short auxiliary window runs from 0xFFFFC0 to 0xFFFFFF. One enable bit in an 8-bit control register decides whether those windows are served from the internal array. Any access that misses both windows, and any access made while the enable bit is clear, is passed to the external bus through a select output.

Byte and word accesses are supported. Each read or write finishes in the cycle in which it is presented. Lanes are big-endian: an even byte address uses data bits 15:8, and an odd byte address uses bits 7:0. A word must start at an even address. A standby input freezes the block. While standby is high, requests and register writes are ignored, and the contents of the register and of the RAM are kept. Only reset reinitialises the enable bit.

Top module: `ram_win_top`

## Requirements
- R1: After reset, `ctl_rdata` reads 0x01. Bit 0 is the enable bit and resets to 1. Bits 7:1 reset to 0.
- R2: A cycle with `ctl_we` high and `standby` low loads `ctl_wdata` into all 8 register bits. The new value is visible on `ctl_rdata` from the next cycle.
- R3: While `standby` is high, register writes and RAM writes are ignored, `ext_sel` is 0, `align_err` is 0 and `rdata` is 0. The register value and the RAM contents are unchanged when standby ends.
- R4: With the enable bit at 1, any address from 0xFFD800 to 0xFFEFBF is served internally, with `ext_sel` at 0. Data written there reads back unchanged.
- R5: The window from 0xFFFFC0 to 0xFFFFFF is served from a 64-byte region of its own. Writes there never change data in the main window, and writes to the main window never change data there.
- R6: An address outside both windows asserts `ext_sel` in the cycle of the request. Examples are 0xFFD7FF, 0xFFEFC0 and 0xFFFFBF. For such an access `rdata` is 0 and the internal RAM is not modified.
- R7: With the enable bit at 0, an access inside either window asserts `ext_sel` and leaves the internal RAM unmodified.
- R8: A byte write (`size_word` = 0) to an even address stores `wdata[15:8]`. A byte write to an odd address stores `wdata[7:0]`. The other byte of that 16-bit word is kept.
- R9: A byte read from an even address returns the byte on `rdata[15:8]` with `rdata[7:0]` = 0. A byte read from an odd address returns it on `rdata[7:0]` with `rdata[15:8]` = 0.
- R10: A word access (`size_word` = 1) to an odd address asserts `align_err` in that cycle. It does not modify the RAM, and it returns `rdata` = 0.
- R11: Read data appears on `rdata` in the cycle of the request. A write takes effect at the clock edge that ends its cycle, so a read in the following cycle sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Freezes requests and register writes; state is retained |
| req | input | 1 | An access is presented this cycle |
| addr | input | 24 | Byte address |
| size_word | input | 1 | 1 = word access, 0 = byte access |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 16 | Write data, big-endian lanes |
| rdata | output | 16 | Read data from the internal RAM; 0 when not served internally |
| ext_sel | output | 1 | Access is routed to the external bus |
| align_err | output | 1 | Word access to an odd address |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| ctl_rdata | output | 8 | Control register contents; bit 0 is the enable bit |

## Verification
Word writes and reads are made at the first and last word of the main window and at both ends of the auxiliary window. These show that the index arithmetic is correct at each edge, and that the two windows do not alias. Byte writes to an even address and then to the neighbouring odd address, followed by a word read and by byte reads, separate correct lane steering and byte preservation from swapped or full-word writes. The addresses one byte past each window boundary separate correct range compares from off-by-one compares. Three further patterns follow the same stimulus with a read of a known word: a write while the enable bit is clear, a misaligned word write, and a write during standby. Each shows whether that access was truly kept away from the array.

// File: rtl/ram_win_pkg.sv
package ram_win_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;
  localparam int CTL_W  = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [LANES-1:0]  lane_t;

  // inclusive range compare
  function automatic logic in_range(addr_t a, addr_t lo, addr_t hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // word offset of a byte address from a window base
  function automatic int unsigned word_off(addr_t a, addr_t lo);
    return int'((a - lo) >> 1);
  endfunction

  // lane 1 = bits 15:8 (even address), lane 0 = bits 7:0 (odd address)
  function automatic lane_t lane_mask(logic word, logic odd);
    if (word)     return 2'b11;
    else if (odd) return 2'b01;
    else          return 2'b10;
  endfunction

  function automatic data_t lane_fill(lane_t m);
    return {{LANE_W{m[1]}}, {LANE_W{m[0]}}};
  endfunction
endpackage

// File: rtl/ram_win_decode.sv
module ram_win_decode
  import ram_win_pkg::*;
#(
  parameter addr_t MAIN_LO    = 24'hFFD800,
  parameter addr_t MAIN_HI    = 24'hFFEFBF,
  parameter addr_t AUX_LO     = 24'hFFFFC0,
  parameter addr_t AUX_HI     = 24'hFFFFFF,
  parameter int    MAIN_WORDS = 3040,
  parameter int    IDX_W      = 12
) (
  input  addr_t            addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  logic main_hit;
  logic aux_hit;

  assign main_hit = in_range(addr, MAIN_LO, MAIN_HI);
  assign aux_hit  = in_range(addr, AUX_LO, AUX_HI);
  assign hit      = main_hit | aux_hit;

  always_comb begin
    if (aux_hit) idx = IDX_W'(MAIN_WORDS + int'(word_off(addr, AUX_LO)));
    else         idx = IDX_W'(word_off(addr, MAIN_LO));
  end
endmodule

// File: rtl/ram_win_ctlreg.sv
module ram_win_ctlreg
  import ram_win_pkg::*;
#(
  parameter logic [CTL_W-1:0] RST_VAL = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CTL_W-1:0] din,
  output logic [CTL_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= RST_VAL;
    else if (load) q <= din;
  end
endmodule

// File: rtl/ram_win_array.sv
module ram_win_array
  import ram_win_pkg::*;
#(
  parameter int DEPTH = 3072,
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             we,
  input  lane_t            be,
  input  logic [IDX_W-1:0] idx,
  input  data_t            wdata,
  output data_t            q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && be[g]) mem[idx] <= wdata[g*LANE_W +: LANE_W];
    end
    assign q[g*LANE_W +: LANE_W] = mem[idx];
  end
endmodule

// File: rtl/ram_win_top.sv
module ram_win_top
  import ram_win_pkg::*;
#(
  parameter addr_t MAIN_LO = 24'hFFD800,
  parameter addr_t MAIN_HI = 24'hFFEFBF,
  parameter addr_t AUX_LO  = 24'hFFFFC0,
  parameter addr_t AUX_HI  = 24'hFFFFFF,
  parameter logic [CTL_W-1:0] CTL_RST = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             req,
  input  logic [ADDR_W-1:0] addr,
  input  logic             size_word,
  input  logic             wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic             ext_sel,
  output logic             align_err,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata
);
  localparam int MAIN_WORDS = int'((MAIN_HI - MAIN_LO + 1) >> 1);
  localparam int AUX_WORDS  = int'((AUX_HI - AUX_LO + 1) >> 1);
  localparam int DEPTH      = MAIN_WORDS + AUX_WORDS;
  localparam int IDX_W      = $clog2(DEPTH);

  logic             win_hit;
  logic [IDX_W-1:0] win_idx;
  logic             ram_en;
  logic             acc;
  logic             misalign;
  logic             int_hit;
  logic             int_wr;
  logic             int_rd;
  lane_t            be;
  data_t            ram_q;

  ram_win_decode #(
    .MAIN_LO(MAIN_LO), .MAIN_HI(MAIN_HI), .AUX_LO(AUX_LO), .AUX_HI(AUX_HI),
    .MAIN_WORDS(MAIN_WORDS), .IDX_W(IDX_W)
  ) u_dec (
    .addr(addr), .hit(win_hit), .idx(win_idx)
  );

  ram_win_ctlreg #(.RST_VAL(CTL_RST)) u_ctl (
    .clk(clk), .rst_n(rst_n), .load(ctl_we & ~standby),
    .din(ctl_wdata), .q(ctl_rdata)
  );

  assign ram_en   = ctl_rdata[0];
  assign acc      = req & ~standby;
  assign misalign = size_word & addr[0];
  assign int_hit  = acc & ram_en & win_hit;
  assign int_wr   = int_hit & wr & ~misalign;
  assign int_rd   = int_hit & ~wr & ~misalign;
  assign be       = lane_mask(size_word, addr[0]);

  ram_win_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
    .clk(clk), .we(int_wr), .be(be), .idx(win_idx), .wdata(wdata), .q(ram_q)
  );

  assign ext_sel   = acc & ~(ram_en & win_hit);
  assign align_err = acc & misalign;
  assign rdata     = int_rd ? (ram_q & lane_fill(be)) : '0;
endmodule

// File: rtl/ram_win_chk.sv
module ram_win_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        standby,
  input logic        size_word,
  input logic        addr0,
  input logic [15:0] rdata,
  input logic        ext_sel,
  input logic        align_err,
  input logic        ctl_we,
  input logic [7:0]  ctl_wdata,
  input logic [7:0]  ctl_rdata,
  input logic        int_wr,
  input logic        int_rd
);
  // R1
  ctl_reset_val_chk: assert property (@(posedge clk) !rst_n |=> ctl_rdata == 8'h01);

  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && !standby |=> ctl_rdata == $past(ctl_wdata));

  // R3
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> $stable(ctl_rdata));

  // R3
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !ext_sel && !align_err && rdata == 16'h0);

  // R6
  ext_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sel |-> !int_wr && !int_rd && rdata == 16'h0);

  // R9
  byte_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_rd && !size_word |-> (addr0 ? rdata[15:8] == 8'h0 : rdata[7:0] == 8'h0));

  // R10
  misalign_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !int_wr && rdata == 16'h0);
endmodule

bind ram_win_top ram_win_chk u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .size_word(size_word),
  .addr0(addr[0]), .rdata(rdata), .ext_sel(ext_sel), .align_err(align_err),
  .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
  .int_wr(int_wr), .int_rd(int_rd)
);

// File: tb/tb_ram_win_top.sv
module tb_ram_win_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic        req = 1'b0;
  logic [23:0] addr = '0;
  logic        size_word = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ext_sel;
  logic        align_err;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] c_rdata;
  logic        c_ext;
  logic        c_aerr;

  always #4 clk = ~clk;

  ram_win_top dut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .req(req), .addr(addr),
    .size_word(size_word), .wr(wr), .wdata(wdata), .rdata(rdata),
    .ext_sel(ext_sel), .align_err(align_err), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // present one access for one cycle, capture outputs mid-cycle
  task automatic acc(logic [23:0] a, logic w, logic isw, logic [15:0] d);
    @(negedge clk);
    req = 1'b1; addr = a; size_word = w; wr = isw; wdata = d;
    #1;
    c_rdata = rdata; c_ext = ext_sel; c_aerr = align_err;
    @(posedge clk);
    #1;
    req = 1'b0; wr = 1'b0;
  endtask

  task automatic ctl_write(logic [7:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(posedge clk);
    #1;
    ctl_we = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ctl after reset", {8'h0, ctl_rdata}, 16'h0001);
    chk("R1 idle ext_sel", {15'h0, ext_sel}, 16'h0);
  endtask

  task automatic t_main();
    acc(24'hFFD800, 1, 1, 16'hA1B2);
    chk("R4 write ext_sel", {15'h0, c_ext}, 16'h0);
    acc(24'hFFD800, 1, 0, 16'h0);
    chk("R11 R4 first word", c_rdata, 16'hA1B2);
    acc(24'hFFEFBE, 1, 1, 16'h1234);
    acc(24'hFFEFBE, 1, 0, 16'h0);
    chk("R4 last word", c_rdata, 16'h1234);
    chk("R4 last word ext_sel", {15'h0, c_ext}, 16'h0);
  endtask

  task automatic t_aux();
    acc(24'hFFFFC0, 1, 1, 16'h5A5A);
    acc(24'hFFFFFE, 1, 1, 16'hC3C3);
    acc(24'hFFD800, 1, 0, 16'h0);
    chk("R5 main kept", c_rdata, 16'hA1B2);
    acc(24'hFFFFC0, 1, 0, 16'h0);
    chk("R5 aux first", c_rdata, 16'h5A5A);
    acc(24'hFFFFFE, 1, 0, 16'h0);
    chk("R5 aux last", c_rdata, 16'hC3C3);
    acc(24'hFFEFBE, 1, 0, 16'h0);
    chk("R5 main last kept", c_rdata, 16'h1234);
  endtask

  task automatic t_lanes();
    acc(24'hFFD800, 0, 1, 16'h77EE);
    acc(24'hFFD800, 1, 0, 16'h0);
    chk("R8 even byte write", c_rdata, 16'h77B2);
    acc(24'hFFD801, 0, 1, 16'h4499);
    acc(24'hFFD800, 1, 0, 16'h0);
    chk("R8 odd byte write", c_rdata, 16'h7799);
    acc(24'hFFD800, 0, 0, 16'h0);
    chk("R9 even byte read", c_rdata, 16'h7700);
    acc(24'hFFD801, 0, 0, 16'h0);
    chk("R9 odd byte read", c_rdata, 16'h0099);
  endtask

  task automatic t_outside();
    acc(24'hFFEFC0, 1, 1, 16'hBEEF);
    chk("R6 above main ext_sel", {15'h0, c_ext}, 16'h1);
    acc(24'hFFD7FF, 0, 0, 16'h0);
    chk("R6 below main ext_sel", {15'h0, c_ext}, 16'h1);
    chk("R6 rdata zero", c_rdata, 16'h0);
    acc(24'hFFFFBF, 0, 1, 16'hFFFF);
    chk("R6 below aux ext_sel", {15'h0, c_ext}, 16'h1);
    acc(24'hFFEFBE, 1, 0, 16'h0);
    chk("R6 ram untouched", c_rdata, 16'h1234);
  endtask

  task automatic t_disable();
    ctl_write(8'h00);
    @(negedge clk);
    chk("R2 ctl cleared", {8'h0, ctl_rdata}, 16'h0000);
    acc(24'hFFD800, 1, 1, 16'hDEAD);
    chk("R7 disabled ext_sel", {15'h0, c_ext}, 16'h1);
    acc(24'hFFFFC0, 1, 0, 16'h0);
    chk("R7 disabled aux ext_sel", {15'h0, c_ext}, 16'h1);
    ctl_write(8'hA5);
    @(negedge clk);
    chk("R2 ctl full byte", {8'h0, ctl_rdata}, 16'h00A5);
    acc(24'hFFD800, 1, 0, 16'h0);
    chk("R7 ram untouched", c_rdata, 16'h7799);
    ctl_write(8'h01);
  endtask

  task automatic t_align();
    acc(24'hFFD801, 1, 1, 16'hFFFF);
    chk("R10 align_err", {15'h0, c_aerr}, 16'h1);
    acc(24'hFFD801, 1, 0, 16'h0);
    chk("R10 misaligned read zero", c_rdata, 16'h0);
    acc(24'hFFD800, 1, 0, 16'h0);
    chk("R10 ram untouched", c_rdata, 16'h7799);
    chk("R10 aligned no err", {15'h0, c_aerr}, 16'h0);
  endtask

  task automatic t_standby();
    @(negedge clk);
    standby = 1'b1;
    ctl_write(8'h00);
    acc(24'hFFD800, 1, 1, 16'h1111);
    chk("R3 standby ext_sel", {15'h0, c_ext}, 16'h0);
    acc(24'hFFEFC0, 1, 0, 16'h0);
    chk("R3 standby outside ext_sel", {15'h0, c_ext}, 16'h0);
    acc(24'hFFD800, 1, 0, 16'h0);
    chk("R3 standby rdata", c_rdata, 16'h0);
    @(negedge clk);
    standby = 1'b0;
    @(negedge clk);
    chk("R3 ctl retained", {8'h0, ctl_rdata}, 16'h0001);
    acc(24'hFFD800, 1, 0, 16'h0);
    chk("R3 ram retained", c_rdata, 16'h7799);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_main();
    t_aux();
    t_lanes();
    t_outside();
    t_disable();
    t_align();
    t_standby();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule